// File: doc/BRIEF.md
# Counted Byte Block-Copy Engine

The engine moves a block of bytes from a source region to a destination region, one byte at a time, in rising address order. Software presents a byte count, a source address and a destination address and pulses a start input. For every byte, the engine first issues a read request at the current source pointer. It then accepts the returned byte and issues a write of that byte at the current destination pointer. After each completed write, both pointers move up by one and the count moves down by one. All three working registers can be read on output pins at all times, so their final values stay visible after the copy ends.

The read request, the read response and the write are separate valid/ready channels. Back-pressure rules are as follows. Once the engine raises a request valid, it keeps that valid high, with address and data unchanged, until the cycle in which the matching ready is high. On the response channel, the engine raises ready only while it waits for a byte, and it accepts the byte in any cycle where valid and ready are both high. The engine never has more than one operation in flight. The start pin, the configuration pins, busy and done are plain level signals.

A count of zero loads the registers and completes without touching memory. Pointer arithmetic wraps at the top of the 32-bit address space.

Top module: `bytecopy_engine`

## Requirements
- R1: After reset, count, source and destination outputs are 0, busy and done are low, and no read request, read response ready or write valid is asserted.
- R2: A start pulse while idle loads the three configuration inputs into the count, source and destination registers, and the loaded values are visible on the outputs in the next cycle.
- R3: A read request carries the current source pointer as its address. While it is not accepted, valid stays high and the address is held.
- R4: The byte written is the byte accepted on the read response channel, and the write valid rises in the cycle after that acceptance.
- R5: A write that is not accepted keeps its valid, address and data unchanged until write ready is high.
- R6: Each accepted write increments source and destination by one and decrements count by one in the following cycle.
- R7: A nonzero count N produces exactly N writes, to destination addresses dst, dst+1, ... dst+N-1, of bytes read from src, src+1, ... in that order. A read and a write are never requested in the same cycle.
- R8: A start with count zero issues no read or write. done pulses in the next cycle, and busy stays low.
- R9: done is high for exactly one cycle, in the cycle after the final accepted write. At that point count is 0 and both pointers equal their start values plus N.
- R10: A start pulse while busy has no effect on the registers or the copy in progress.
- R11: Pointer increments wrap modulo 2^32.
- R12: While idle, the engine asserts no read request, response ready or write valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| cfg_count_i | input | 32 | Number of bytes to copy |
| cfg_src_i | input | 32 | First source address |
| cfg_dst_i | input | 32 | First destination address |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 32 | Remaining byte count |
| src_o | output | 32 | Current source pointer |
| dst_o | output | 32 | Current destination pointer |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request ready |
| rd_req_addr_o | output | 32 | Read request address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_ready_o | output | 1 | Read response ready |
| rd_rsp_data_i | input | 8 | Read response byte |
| wr_valid_o | output | 1 | Write valid |
| wr_ready_i | input | 1 | Write ready |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 8 | Write byte |

## Verification
The assertions check the following on every cycle: request and write stability under back-pressure, the forwarding of each accepted response byte to the next write, the one-step register update after every accepted write, the single-cycle done pulse with a zero count, the absence of traffic while idle, and the absence of any register change when start arrives mid-copy. Other properties are whole-run properties that only the bench scenarios can show. These are the exact number and order of copied bytes, the final pointer values, the zero-count case completing with no traffic, and wraparound past the top of the address space. The scenarios run under steady, alternating and pseudo-random ready patterns.

// File: rtl/bcopy_pkg.sv
package bcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_AWAIT = 2'd2,
    ST_STORE = 2'd3
  } bc_state_e;
endpackage

// File: rtl/bcopy_stepreg.sv
// Loadable register that moves by one per step; DOWN picks the direction.
module bcopy_stepreg #(
  parameter int W    = 32,
  parameter bit DOWN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] UNIT = W'(1);

  logic [W-1:0] val_q;
  logic [W-1:0] nxt;

  generate
    if (DOWN) begin : g_dec
      assign nxt = val_q - UNIT;
    end else begin : g_inc
      assign nxt = val_q + UNIT;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (step_i) val_q <= nxt;
  end

  assign val_o = val_q;
endmodule

// File: rtl/bcopy_seq.sv
// Per-byte sequencer: fetch request, await byte, store byte.
module bcopy_seq
  import bcopy_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              zero_len_i,
  input  logic              last_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              load_o,
  output logic              step_o,
  output logic              busy_o,
  output logic              done_o
);
  bc_state_e         state_q, state_d;
  logic [DATA_W-1:0] hold_q;
  logic              done_q;
  logic              take_byte;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign step_o    = (state_q == ST_STORE) && wr_ready_i;
  assign take_byte = (state_q == ST_AWAIT) && rd_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i && !zero_len_i) state_d = ST_FETCH;
      ST_FETCH: if (rd_req_ready_i)         state_d = ST_AWAIT;
      ST_AWAIT: if (rd_rsp_valid_i)         state_d = ST_STORE;
      ST_STORE: if (wr_ready_i)             state_d = last_i ? ST_IDLE : ST_FETCH;
      default:                              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_byte) hold_q <= rd_rsp_data_i;
      done_q <= (load_o && zero_len_i) || (step_o && last_i);
    end
  end

  assign rd_req_valid_o = (state_q == ST_FETCH);
  assign rd_rsp_ready_o = (state_q == ST_AWAIT);
  assign wr_valid_o     = (state_q == ST_STORE);
  assign wr_data_o      = hold_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
endmodule

// File: rtl/bytecopy_engine.sv
module bytecopy_engine #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

  logic load, step, last_byte, zero_len;

  assign zero_len  = (cfg_count_i == '0);
  assign last_byte = (count_o == ONE_LEFT);

  bcopy_seq #(.DATA_W(DATA_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .zero_len_i     (zero_len),
    .last_i         (last_byte),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .rd_rsp_ready_o (rd_rsp_ready_o),
    .rd_rsp_data_i  (rd_rsp_data_i),
    .wr_valid_o     (wr_valid_o),
    .wr_ready_i     (wr_ready_i),
    .wr_data_o      (wr_data_o),
    .load_o         (load),
    .step_o         (step),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  bcopy_stepreg #(.W(CNT_W), .DOWN(1'b1)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(cfg_count_i),
    .step_i(step), .val_o(count_o)
  );

  bcopy_stepreg #(.W(ADDR_W), .DOWN(1'b0)) u_src (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(cfg_src_i),
    .step_i(step), .val_o(src_o)
  );

  bcopy_stepreg #(.W(ADDR_W), .DOWN(1'b0)) u_dst (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(cfg_dst_i),
    .step_i(step), .val_o(dst_o)
  );

  assign rd_req_addr_o = src_o;
  assign wr_addr_o     = dst_o;
endmodule

// File: rtl/bytecopy_engine_chk.sv
module bytecopy_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [ADDR_W-1:0] src_o,
  input logic [ADDR_W-1:0] dst_o,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [ADDR_W-1:0] rd_req_addr_o,
  input logic              rd_rsp_valid_i,
  input logic              rd_rsp_ready_o,
  input logic [DATA_W-1:0] rd_rsp_data_i,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));

  // R4
  fwd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid_i && rd_rsp_ready_o |=> wr_valid_o && (wr_data_o == $past(rd_rsp_data_i)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_ready_i |=> (count_o == $past(count_o) - CNT_W'(1))
      && (src_o == $past(src_o) + ADDR_W'(1)) && (dst_o == $past(dst_o) + ADDR_W'(1)));

  // R7
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid_o && wr_valid_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (count_o == '0) && !busy_o);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !(wr_valid_o && wr_ready_i) |=>
      $stable(count_o) && $stable(src_o) && $stable(dst_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_valid_o && !rd_rsp_ready_o && !wr_valid_o);
endmodule

bind bytecopy_engine bytecopy_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .count_o(count_o), .src_o(src_o), .dst_o(dst_o),
  .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
  .rd_req_addr_o(rd_req_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
  .rd_rsp_ready_o(rd_rsp_ready_o), .rd_rsp_data_i(rd_rsp_data_i),
  .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
);

// File: tb/bytecopy_engine_bench.sv
module bytecopy_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] cfg_count_i = '0, cfg_src_i = '0, cfg_dst_i = '0;
  logic        busy_o, done_o;
  logic [31:0] count_o, src_o, dst_o;
  logic        rd_req_valid_o, rd_req_ready_i = 1'b0;
  logic [31:0] rd_req_addr_o;
  logic        rd_rsp_valid_i = 1'b0, rd_rsp_ready_o;
  logic [7:0]  rd_rsp_data_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b0;
  logic [31:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  always #4 clk = ~clk;  // 125 MHz

  bytecopy_engine u_bytecopy_engine (.*);

  typedef struct packed { logic [31:0] a; logic [7:0] d; } exp_t;
  exp_t sb_q[$];

  int checks = 0, fails = 0;
  int rd_events = 0, wr_events = 0;
  int mode = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        rd_go = 1'b0, rsp_take = 1'b0;
  logic [31:0] rd_addr_saved = '0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic pick_ready();
    case (mode)
      1:       return cyc[0];
      2:       return lfsr[0] | lfsr[3];
      default: return 1'b1;
    endcase
  endfunction

  // memory model and scoreboard monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rsp_take) rd_rsp_valid_i = 1'b0;
    if (rd_go) begin
      rd_rsp_valid_i = 1'b1;
      rd_rsp_data_i  = pat(rd_addr_saved);
    end
    rd_req_ready_i = pick_ready();
    rd_go = rd_req_valid_o && rd_req_ready_i;
    if (rd_go) begin
      rd_events++;
      rd_addr_saved = rd_req_addr_o;
      // R3: read address is the visible source pointer
      check(rd_req_addr_o == src_o, "R3", "read address", rd_req_addr_o, src_o);
    end
    rsp_take = rd_rsp_valid_i && rd_rsp_ready_o;
    wr_ready_i = pick_ready() | cyc[2];
    if (wr_valid_o && wr_ready_i) begin
      wr_events++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "unexpected write", wr_addr_o, 32'h0);
      end else begin
        exp_t e;
        // R6: count tracks remaining bytes
        check(count_o == 32'(sb_q.size()), "R6", "remaining count", count_o, 32'(sb_q.size()));
        e = sb_q.pop_front();
        check(wr_addr_o == e.a, "R7", "write address", wr_addr_o, e.a);
        check(wr_data_o == e.d, "R4", "write data", {24'h0, wr_data_o}, {24'h0, e.d});
      end
    end
  end

  task automatic run_copy(input logic [31:0] n, input logic [31:0] s,
                          input logic [31:0] d, input int m, input bit poke);
    int rd0, wr0, waited;
    mode = m;
    for (int i = 0; i < int'(n); i++)
      sb_q.push_back('{a: d + 32'(i), d: pat(s + 32'(i))});
    @(negedge clk);
    rd0 = rd_events; wr0 = wr_events;
    cfg_count_i = n; cfg_src_i = s; cfg_dst_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(count_o == n, "R2", "loaded count", count_o, n);
    check(src_o == s, "R2", "loaded source", src_o, s);
    check(dst_o == d, "R2", "loaded destination", dst_o, d);
    if (n == 0) begin
      check(done_o == 1'b1, "R8", "done after zero count", 32'(done_o), 1);
      check(busy_o == 1'b0, "R8", "busy on zero count", 32'(busy_o), 0);
      @(negedge clk);
      check(rd_events == rd0 && wr_events == wr0, "R8", "accesses on zero count",
            32'(rd_events - rd0 + wr_events - wr0), 0);
      check(done_o == 1'b0, "R9", "done width", 32'(done_o), 0);
      return;
    end
    check(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 1);
    waited = 0;
    while (!done_o && waited < 4000) begin
      if (poke && waited == 3) begin
        cfg_count_i = 32'h55; cfg_src_i = 32'h9999_0000; cfg_dst_i = 32'h7777_0000;
        start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      waited++;
    end
    start_i = 1'b0;
    check(done_o == 1'b1, "R9", "done seen", 32'(done_o), 1);
    check(count_o == 32'h0, "R9", "final count", count_o, 0);
    check(src_o == s + n, "R9", "final source", src_o, s + n);
    check(dst_o == d + n, "R9", "final destination", dst_o, d + n);
    check(wr_events - wr0 == int'(n), "R7", "write total", 32'(wr_events - wr0), n);
    check(sb_q.size() == 0, "R7", "scoreboard drained", 32'(sb_q.size()), 0);
    if (poke) check(src_o == s + n, "R10", "busy start ignored", src_o, s + n);
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done width", 32'(done_o), 0);
    check(busy_o == 1'b0 && !rd_req_valid_o && !wr_valid_o, "R12", "idle quiet",
          {busy_o, rd_req_valid_o, wr_valid_o}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(count_o == 0 && src_o == 0 && dst_o == 0, "R1", "reset registers", count_o | src_o | dst_o, 0);
        check(!busy_o && !done_o, "R1", "reset status", {busy_o, done_o}, 0);
        check(!rd_req_valid_o && !rd_rsp_ready_o && !wr_valid_o, "R1", "reset handshakes",
              {rd_req_valid_o, rd_rsp_ready_o, wr_valid_o}, 0);
        run_copy(32'd5, 32'h0000_0100, 32'h0000_2000, 0, 1'b0);
        run_copy(32'd7, 32'h0001_0A30, 32'h0003_0005, 1, 1'b0);
        run_copy(32'd16, 32'h1234_5600, 32'h00AB_CD00, 2, 1'b0);
        run_copy(32'd0, 32'h4000_0000, 32'h5000_0000, 2, 1'b0);   // R8
        run_copy(32'd1, 32'h0000_00FF, 32'h0000_0100, 1, 1'b0);
        run_copy(32'd4, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 2, 1'b0);   // R11 wrap
        check(src_o == 32'h0000_0002, "R11", "source wrapped", src_o, 32'h2);
        check(dst_o == 32'h0000_0003, "R11", "destination wrapped", dst_o, 32'h3);
        run_copy(32'd6, 32'h0000_0400, 32'h0000_0800, 2, 1'b1);   // R10
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule